// File: doc/BRIEF.md
# Maskable Link Alarm Interrupt Aggregator

This block collects fault levels from three sublayers in each direction, receive and transmit. It holds each fault in a sticky status bit and filters the faults through a two-level mask before they reach one interrupt pin. First, per-event enables combine the status bits into a receive group alarm and a transmit group alarm. Then a separate interrupt control register gates those two groups, together with a latched link-status event, onto an active-low open-drain interrupt output.

The six registers sit on a simple single-cycle register port. There are two fault-enable registers, one interrupt-enable register, two fault-status registers and one interrupt-status register. A polling sequencer supplies the fault levels. A host reads the status registers to find and acknowledge the cause of an interrupt. A read of a status register clears its sticky bits, except for faults that are still present.

Top module: `la_alarm_agg`

## Requirements
- R1: After reset, the receive and transmit enable registers (0x9000, 0x9001) read 0x0019. The interrupt control register (0x9002) reads 0x0000. Both fault-status registers (0x9003, 0x9004) and the interrupt status register (0x9005) read 0x0000, and `irq_n` is 1.
- R2: A read strobe in one cycle returns the addressed register on `reg_rdata` with `reg_rvalid` high in the next cycle. Any address outside 0x9000..0x9005 reads 0x0000.
- R3: In 0x9000 and 0x9001 only bits 4, 3 and 0 can be written. In 0x9002 only bits 2:0 can be written. All other bits read 0. Writes to 0x9003..0x9005 have no effect.
- R4: Fault bit i maps to a status bit as follows: index 0 (PMA/PMD) goes to bit 4, index 1 (PCS) to bit 3, and index 2 (PHY XS) to bit 0. This holds for `rx_fault` into 0x9003 and for `tx_fault` into 0x9004. A fault level present at a clock edge sets its status bit at that edge, whatever the enables hold.
- R5: A read of a fault-status register returns the value before the clear. It then clears every bit whose fault input is low at the read edge. A bit whose fault is still high stays set.
- R6: Bit 2 of 0x9005 is the OR of the receive status bits ANDed with their enables in 0x9000. Bit 1 is the same for transmit with 0x9001.
- R7: A high `ls_event` sets bit 0 of 0x9005, which clears when 0x9005 is read unless `ls_event` is still high. Bit 3 of 0x9005 shows `host_grant` as sampled on the previous edge.
- R8: `irq_n` is 0 when any of these holds: the receive group alarm with 0x9002 bit 2, the transmit group alarm with bit 1, or the link-status bit with bit 0. It changes at the same edge as the status that causes it.
- R9: Writing 0 to an interrupt enable releases `irq_n` at the edge of the write, with no status read. Setting the enable again re-asserts the interrupt while the status is still set.
- R10: A fault whose per-event enable is 0 still latches in its status register, but it raises neither its group alarm nor `irq_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| rx_fault | input | 3 | Receive fault levels: PMA/PMD, PCS, PHY XS |
| tx_fault | input | 3 | Transmit fault levels: PMA/PMD, PCS, PHY XS |
| ls_event | input | 1 | Link-status event level |
| host_grant | input | 1 | Host holds the indirect management grant |
| irq_n | output | 1 | Open-drain interrupt level: 0 pulls low, 1 releases |

## Verification
The hardest state to reach is a sticky status bit that stays set while its fault is gone and its interrupt enable has been cleared. In that state the interrupt must be released even though nothing was read. The bench creates it with one-cycle fault pulses, an enable write and a re-enable. It then checks `irq_n` at the write edge and reads the status afterwards to show the bit survived. A second case holds a fault high across a status read, to show that the read clears only faults that have gone. Another case masks one event in the per-event register and still finds its status latched.

// File: rtl/la_pkg.sv
package la_pkg;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 16;
    localparam int EV_N   = 3;
    // register bit used by each fault index; decoded by host software
    localparam int EV_POS [EV_N] = '{4, 3, 0};

    function automatic logic [REG_W-1:0] ev_pack(input logic [EV_N-1:0] v);
        logic [REG_W-1:0] r;
        r = '0;
        for (int i = 0; i < EV_N; i++) r[EV_POS[i]] = v[i];
        return r;
    endfunction

    function automatic logic [EV_N-1:0] ev_unpack(input logic [REG_W-1:0] d);
        logic [EV_N-1:0] r;
        for (int i = 0; i < EV_N; i++) r[i] = d[EV_POS[i]];
        return r;
    endfunction
endpackage

// File: rtl/la_fault_bank.sv
module la_fault_bank #(
    parameter int EV_N = 3,
    parameter logic [EV_N-1:0] CTRL_RST = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_N-1:0] fault_i,
    input  logic            ctrl_we,
    input  logic [EV_N-1:0] ctrl_wv,
    input  logic            stat_rd,
    output logic [EV_N-1:0] ctrl_o,
    output logic [EV_N-1:0] stat_o,
    output logic            grp_nx_o
);
    typedef struct packed {
        logic [EV_N-1:0] ctrl;
        logic [EV_N-1:0] stat;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_we) st_d.ctrl = ctrl_wv;
        st_d.stat = fault_i | (st_q.stat & {EV_N{~stat_rd}});
        grp_nx_o  = |(st_d.stat & st_d.ctrl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= CTRL_RST;
            st_q.stat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.ctrl;
    assign stat_o = st_q.stat;

    // R4: a present fault is visible in status after the edge
    a_r4_fault_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_i) |=> ((stat_o & $past(fault_i)) == $past(fault_i)));
    // R5: set bits hold until a read
    a_r5_hold_until_read: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((stat_o & $past(stat_o)) == $past(stat_o)));
    // R5: a read with no fault present empties the register
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && fault_i == '0) |=> (stat_o == '0));
endmodule

// File: rtl/la_irq_core.sv
module la_irq_core #(
    parameter int GRP_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_grp_nx,
    input  logic             tx_grp_nx,
    input  logic             ls_i,
    input  logic             grant_i,
    input  logic             en_we,
    input  logic [GRP_N-1:0] en_wv,
    input  logic             lstat_rd,
    output logic [GRP_N-1:0] en_o,
    output logic [GRP_N:0]   lstat_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [GRP_N-1:0] en;
        logic             grp_rx;
        logic             grp_tx;
        logic             ls;
        logic             grant;
        logic             irq;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_we) st_d.en = en_wv;
        st_d.grp_rx = rx_grp_nx;
        st_d.grp_tx = tx_grp_nx;
        st_d.ls     = ls_i | (st_q.ls & ~lstat_rd);
        st_d.grant  = grant_i;
        st_d.irq    = |(st_d.en & {st_d.grp_rx, st_d.grp_tx, st_d.ls});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o    = st_q.en;
    assign lstat_o = {st_q.grant, st_q.grp_rx, st_q.grp_tx, st_q.ls};
    assign irq_o   = st_q.irq;

    // R8: interrupt only with an enabled source
    a_r8_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((en_o & lstat_o[GRP_N-1:0]) != '0));
    // R9: writing all enables to zero releases the pin at once
    a_r9_disable_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we && en_wv == '0) |=> !irq_o);
    // R7: grant bit follows its input by one edge
    a_r7_grant_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lstat_o[GRP_N] == $past(grant_i)));
endmodule

// File: rtl/la_alarm_agg.sv
module la_alarm_agg
    import la_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE = 16'h9000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              reg_rvalid,
    input  logic [EV_N-1:0]   rx_fault,
    input  logic [EV_N-1:0]   tx_fault,
    input  logic              ls_event,
    input  logic              host_grant,
    output logic              irq_n
);
    localparam int DIR_N = 2;
    localparam int GRP_N = 3;
    localparam logic [ADDR_W-1:0] A_ICTL = BASE + ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_ISTA = BASE + ADDR_W'(5);

    logic [DIR_N-1:0][EV_N-1:0] fault_a, ctrl_a, stat_a;
    logic [DIR_N-1:0]           ctrl_we_a, stat_rd_a, grp_a;
    logic [GRP_N-1:0]           en_q;
    logic [GRP_N:0]             lstat_q;
    logic                       irq_q;
    logic                       unused_wbits;

    assign fault_a[0]   = rx_fault;
    assign fault_a[1]   = tx_fault;
    assign unused_wbits = ^reg_wdata;

    for (genvar g = 0; g < DIR_N; g++) begin : g_dir
        assign ctrl_we_a[g] = reg_wr && (reg_addr == BASE + ADDR_W'(g));
        assign stat_rd_a[g] = reg_rd && (reg_addr == BASE + ADDR_W'(3 + g));
        la_fault_bank #(.EV_N(EV_N), .CTRL_RST({EV_N{1'b1}})) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .fault_i  (fault_a[g]),
            .ctrl_we  (ctrl_we_a[g]),
            .ctrl_wv  (ev_unpack(reg_wdata)),
            .stat_rd  (stat_rd_a[g]),
            .ctrl_o   (ctrl_a[g]),
            .stat_o   (stat_a[g]),
            .grp_nx_o (grp_a[g])
        );
    end

    la_irq_core #(.GRP_N(GRP_N)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_grp_nx (grp_a[0]),
        .tx_grp_nx (grp_a[1]),
        .ls_i      (ls_event),
        .grant_i   (host_grant),
        .en_we     (reg_wr && (reg_addr == A_ICTL)),
        .en_wv     (reg_wdata[GRP_N-1:0]),
        .lstat_rd  (reg_rd && (reg_addr == A_ISTA)),
        .en_o      (en_q),
        .lstat_o   (lstat_q),
        .irq_o     (irq_q)
    );

    typedef struct packed {
        logic [REG_W-1:0] rdata;
        logic             rvalid;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d.rvalid = reg_rd;
        rd_d.rdata  = '0;
        if (reg_rd) begin
            for (int g = 0; g < DIR_N; g++) begin
                if (reg_addr == BASE + ADDR_W'(g))     rd_d.rdata = ev_pack(ctrl_a[g]);
                if (reg_addr == BASE + ADDR_W'(3 + g)) rd_d.rdata = ev_pack(stat_a[g]);
            end
            if (reg_addr == A_ICTL) rd_d.rdata = REG_W'(en_q);
            if (reg_addr == A_ISTA) rd_d.rdata = REG_W'(lstat_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign reg_rdata  = rd_q.rdata;
    assign reg_rvalid = rd_q.rvalid;
    assign irq_n      = ~irq_q;

    // R2: read data arrives one cycle after the strobe
    a_r2_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);
    // R3: upper bits are never set on the read port
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid |-> (reg_rdata[REG_W-1:5] == '0));
    // R2: out-of-range reads return zero
    a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr < BASE || reg_addr > A_ISTA)) |=> (reg_rdata == '0));
endmodule

// File: tb/tb_la_alarm_agg.sv
module tb_la_alarm_agg;
    logic        clk = 0, rst_n = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [15:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
    logic        reg_rvalid;
    logic [2:0]  rx_fault = 0, tx_fault = 0;
    logic        ls_event = 0, host_grant = 0, irq_n;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    la_alarm_agg dut (.*);

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        @(negedge clk); reg_rd = 0;
        if (reg_rvalid !== 1'b1) begin
            n_bad++;
            $display("FAIL R2 rvalid got=%b exp=1", reg_rvalid);
        end
        d = reg_rdata;
    endtask

    task automatic pulse_rx(input logic [2:0] v);
        @(negedge clk); rx_fault = v;
        @(negedge clk); rx_fault = 0;
    endtask

    task automatic pulse_tx(input logic [2:0] v);
        @(negedge clk); tx_fault = v;
        @(negedge clk); tx_fault = 0;
    endtask

    task automatic t_reset;
        logic [15:0] d;
        rd(16'h9000, d); chk("R1 rx enables", d, 16'h0019);
        rd(16'h9001, d); chk("R1 tx enables", d, 16'h0019);
        rd(16'h9002, d); chk("R1 irq enables", d, 16'h0000);
        rd(16'h9003, d); chk("R1 rx status", d, 16'h0000);
        rd(16'h9004, d); chk("R1 tx status", d, 16'h0000);
        rd(16'h9005, d); chk("R1 irq status", d, 16'h0000);
        chk("R1 irq_n", {15'b0, irq_n}, 16'h0001);
    endtask

    task automatic t_regs;
        logic [15:0] d;
        wr(16'h9000, 16'hFFFF); rd(16'h9000, d); chk("R3 rx enable mask", d, 16'h0019);
        wr(16'h9001, 16'h0008); rd(16'h9001, d); chk("R3 tx enable write", d, 16'h0008);
        wr(16'h9002, 16'hFFFF); rd(16'h9002, d); chk("R3 irq enable mask", d, 16'h0007);
        wr(16'h9003, 16'hFFFF); rd(16'h9003, d); chk("R3 status write ignored", d, 16'h0000);
        wr(16'h9005, 16'hFFFF); rd(16'h9005, d); chk("R3 irq status write ignored", d, 16'h0000);
        chk("R3 irq_n after ro writes", {15'b0, irq_n}, 16'h0001);
        rd(16'h9006, d); chk("R2 unmapped high", d, 16'h0000);
        rd(16'h8FFF, d); chk("R2 unmapped low", d, 16'h0000);
        wr(16'h9001, 16'h0019);
        wr(16'h9002, 16'h0000);
    endtask

    task automatic t_latch;
        logic [15:0] d;
        pulse_rx(3'b010);
        chk("R4 no irq with enables off", {15'b0, irq_n}, 16'h0001);
        rd(16'h9003, d); chk("R4 PCS rx at bit3", d, 16'h0008);
        rd(16'h9003, d); chk("R5 cleared after read", d, 16'h0000);
        @(negedge clk); tx_fault = 3'b100;
        rd(16'h9004, d); chk("R4 PHY XS tx at bit0", d, 16'h0001);
        rd(16'h9004, d); chk("R5 held while fault present", d, 16'h0001);
        tx_fault = 0;
        rd(16'h9004, d); chk("R5 last read kept bit", d, 16'h0001);
        rd(16'h9004, d); chk("R5 cleared once fault gone", d, 16'h0000);
    endtask

    task automatic t_irq;
        logic [15:0] d;
        wr(16'h9002, 16'h0004);
        pulse_rx(3'b001);
        chk("R8 irq_n low on rx fault", {15'b0, irq_n}, 16'h0000);
        rd(16'h9005, d); chk("R6 rx group bit2", d, 16'h0004);
        rd(16'h9003, d); chk("R4 PMA/PMD rx at bit4", d, 16'h0010);
        chk("R8 irq_n released after status read", {15'b0, irq_n}, 16'h0001);
    endtask

    task automatic t_disable;
        logic [15:0] d;
        wr(16'h9002, 16'h0002);
        pulse_tx(3'b010);
        chk("R8 irq_n low on tx fault", {15'b0, irq_n}, 16'h0000);
        wr(16'h9002, 16'h0000);
        chk("R9 irq_n released by enable clear", {15'b0, irq_n}, 16'h0001);
        wr(16'h9002, 16'h0002);
        chk("R9 irq_n back on re-enable", {15'b0, irq_n}, 16'h0000);
        rd(16'h9004, d); chk("R9 status kept without read", d, 16'h0008);
        chk("R9 irq_n released after read", {15'b0, irq_n}, 16'h0001);
    endtask

    task automatic t_mask;
        logic [15:0] d;
        wr(16'h9001, 16'h0011);
        pulse_tx(3'b010);
        chk("R10 masked event no irq", {15'b0, irq_n}, 16'h0001);
        rd(16'h9005, d); chk("R10 masked event no group", d, 16'h0000);
        rd(16'h9004, d); chk("R10 masked event still latched", d, 16'h0008);
        wr(16'h9001, 16'h0019);
        wr(16'h9002, 16'h0000);
    endtask

    task automatic t_ls;
        logic [15:0] d;
        wr(16'h9002, 16'h0001);
        @(negedge clk); ls_event = 1;
        @(negedge clk); ls_event = 0;
        chk("R8 irq_n low on link event", {15'b0, irq_n}, 16'h0000);
        rd(16'h9005, d); chk("R7 link bit0 set", d, 16'h0001);
        chk("R7 irq_n released after read", {15'b0, irq_n}, 16'h0001);
        rd(16'h9005, d); chk("R7 link bit0 cleared", d, 16'h0000);
        @(negedge clk); host_grant = 1;
        rd(16'h9005, d); chk("R7 grant bit3", d, 16'h0008);
        host_grant = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_regs();
        t_latch();
        t_irq();
        t_disable();
        t_mask();
        t_ls();
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog got=hang exp=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule